// File: doc/BRIEF.md
# Boundary-Scan Instruction Register and Decoder

This block is the instruction side of a boundary-scan test port for a device that has no identification register. It holds an 8-bit instruction shift register and its update latch, a single-stage bypass register, the decode from the latched opcode to the few controls the boundary-scan register needs, and the falling-edge output stage that drives the serial test output and its enable. An external TAP state machine supplies one-hot state strobes for test-logic-reset, capture, shift and update. The boundary-scan register supplies its own serial output bit.

When the instruction path is captured, the register loads the fixed value 00111101. Software can shift this value out as a substitute for an identification code and confirm that the right device sits at that place in the chain. Four opcodes are decoded. Any other value falls back to bypass, so an unknown opcode can never put the pins into a test state.

Top module: `scan_ir_ctrl`

## Requirements
- R1: An asynchronous reset (`rst_n` low) or a clock edge with `tap_reset` high loads the bypass opcode (all ones) into the update latch. After that, `instr_code` is 4, `bsr_drive`, `out_hiz` and `bsr_select` are 0, and `tdo_en` is 0.
- R2: A clock edge with `ir_capture` high loads 00111101 into the instruction shift register. Shifting then presents it on `tdo` least significant bit first: 1,0,1,1,1,1,0,0.
- R3: Each rising edge with `ir_shift` high moves the shift register one place toward bit 0 and takes `tdi` into bit 7. After eight shifts the register holds the eight `tdi` bits, with the first bit in bit 0.
- R4: The update latch, and so every decoded output, changes only on a rising edge with `ir_update` or `tap_reset` high. Capture and shift leave it unchanged.
- R5: `instr_code` is 0 for opcode 00000000 (drive pins from scan cells), 1 for 10000001 (sample/preload), 2 for 10000010 (clamp), 3 for 00000011 (high impedance) and 4 for bypass.
- R6: Every opcode other than the four in R5 decodes to `instr_code` 4.
- R7: `bsr_select` is 1 only for codes 0 and 1. For all other codes the bypass register sits between `tdi` and `tdo` during data shifts.
- R8: `bsr_drive` is 1 only for codes 0 and 2, and `out_hiz` is 1 only for code 3. The two are never high together.
- R9: A rising edge with `dr_capture` high clears the bypass register. During a data shift with bypass selected, `tdo` repeats `tdi` one clock later, and the first bit out is 0.
- R10: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is 1 after a falling edge seen with `ir_shift` or `dr_shift` high, and 0 otherwise. During a data shift with `bsr_select` high, `tdo` carries `bsr_tdo`.
- R11: When `tap_reset` and `ir_update` are high on the same edge, `tap_reset` wins and the latch holds bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tdi | input | 1 | Serial test data in |
| tap_reset | input | 1 | TAP in test-logic-reset |
| ir_capture | input | 1 | TAP in capture state of the instruction path |
| ir_shift | input | 1 | TAP in shift state of the instruction path |
| ir_update | input | 1 | TAP in update state of the instruction path |
| dr_capture | input | 1 | TAP in capture state of the data path |
| dr_shift | input | 1 | TAP in shift state of the data path |
| bsr_tdo | input | 1 | Serial output of the boundary-scan register |
| instr_code | output | 3 | Active instruction, encoded as in R5 |
| bsr_select | output | 1 | Boundary-scan register is the selected data register |
| bsr_drive | output | 1 | Boundary-scan register drives the pins from its update latches |
| out_hiz | output | 1 | All system outputs forced to high impedance |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for `tdo` (low means high impedance) |

## Verification
The bench sweeps all 256 opcodes through full instruction scans. An opcode that is near a decoded value but wrong, such as 0x80, 0x01, 0x02 or 0x83, would show up in a design that compares only some of the bits and returns a test instruction instead of bypass. On every scan the bench reads the captured value bit by bit, which catches a reversed shift direction or a wrong capture constant. It also checks that the decoded outputs do not move during the scan, which catches a design that decodes the shift register instead of the latch. Data scans through bypass check the leading zero and the one-clock delay, and scans with the boundary register selected check that `tdo` follows `bsr_tdo`. A final case raises test-logic-reset and update together, where a wrong priority would leave the pins in drive mode.

// File: rtl/scan_ir_pkg.sv
`timescale 1ns/1ps
package scan_ir_pkg;

    typedef enum logic [2:0] {
        INS_EXTEST = 3'd0,
        INS_SAMPLE = 3'd1,
        INS_CLAMP  = 3'd2,
        INS_HIGHZ  = 3'd3,
        INS_BYPASS = 3'd4
    } instr_e;

endpackage

// File: rtl/scan_ir_chain.sv
`timescale 1ns/1ps
module scan_ir_chain #(
    parameter int                IR_W        = 8,
    parameter logic [IR_W-1:0]   CAPTURE_VAL = 8'b0011_1101,
    parameter logic [IR_W-1:0]   RESET_OP    = '1
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            tap_reset,
    input  logic            ir_capture,
    input  logic            ir_shift,
    input  logic            ir_update,
    output logic [IR_W-1:0] shreg,
    output logic [IR_W-1:0] hold
);

    typedef struct packed {
        logic [IR_W-1:0] shreg;
        logic [IR_W-1:0] hold;
    } chain_t;

    chain_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ir_capture) begin
            s_d.shreg = CAPTURE_VAL;
        end else if (ir_shift) begin
            s_d.shreg = {tdi, s_q.shreg[IR_W-1:1]};
        end
        if (tap_reset) begin
            s_d.hold = RESET_OP;
        end else if (ir_update) begin
            s_d.hold = s_q.shreg;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shreg <= CAPTURE_VAL;
            s_q.hold  <= RESET_OP;
        end else begin
            s_q <= s_d;
        end
    end

    assign shreg = s_q.shreg;
    assign hold  = s_q.hold;

endmodule

// File: rtl/scan_ir_decode.sv
`timescale 1ns/1ps
module scan_ir_decode
    import scan_ir_pkg::*;
#(
    parameter int              IR_W      = 8,
    parameter logic [IR_W-1:0] OP_EXTEST = 8'b0000_0000,
    parameter logic [IR_W-1:0] OP_SAMPLE = 8'b1000_0001,
    parameter logic [IR_W-1:0] OP_CLAMP  = 8'b1000_0010,
    parameter logic [IR_W-1:0] OP_HIGHZ  = 8'b0000_0011
) (
    input  logic [IR_W-1:0] hold,
    output instr_e          instr,
    output logic            bsr_select,
    output logic            bsr_drive,
    output logic            out_hiz
);

    always_comb begin
        if (hold == OP_EXTEST) begin
            instr = INS_EXTEST;
        end else if (hold == OP_SAMPLE) begin
            instr = INS_SAMPLE;
        end else if (hold == OP_CLAMP) begin
            instr = INS_CLAMP;
        end else if (hold == OP_HIGHZ) begin
            instr = INS_HIGHZ;
        end else begin
            instr = INS_BYPASS;
        end
    end

    always_comb begin
        bsr_select = 1'b0;
        bsr_drive  = 1'b0;
        out_hiz    = 1'b0;
        unique case (instr)
            INS_EXTEST: begin
                bsr_select = 1'b1;
                bsr_drive  = 1'b1;
            end
            INS_SAMPLE: bsr_select = 1'b1;
            INS_CLAMP:  bsr_drive  = 1'b1;
            INS_HIGHZ:  out_hiz    = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/scan_bypass_cell.sv
`timescale 1ns/1ps
module scan_bypass_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic tdi,
    input  logic dr_capture,
    input  logic dr_shift,
    output logic bit_q
);

    typedef struct packed {
        logic stage;
    } byp_t;

    byp_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (dr_capture) begin
            b_d.stage = 1'b0;
        end else if (dr_shift) begin
            b_d.stage = tdi;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            b_q.stage <= 1'b0;
        end else begin
            b_q <= b_d;
        end
    end

    assign bit_q = b_q.stage;

endmodule

// File: rtl/scan_tdo_stage.sv
`timescale 1ns/1ps
module scan_tdo_stage (
    input  logic tck,
    input  logic rst_n,
    input  logic ir_shift,
    input  logic dr_shift,
    input  logic ir_lsb,
    input  logic bsr_select,
    input  logic bsr_tdo,
    input  logic byp_bit,
    output logic tdo,
    output logic tdo_en
);

    typedef struct packed {
        logic data;
        logic en;
    } out_t;

    out_t o_d, o_q;
    logic dr_bit;

    assign dr_bit = bsr_select ? bsr_tdo : byp_bit;

    always_comb begin
        o_d = o_q;
        o_d.en = ir_shift | dr_shift;
        if (ir_shift) begin
            o_d.data = ir_lsb;
        end else if (dr_shift) begin
            o_d.data = dr_bit;
        end
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tdo    = o_q.data;
    assign tdo_en = o_q.en;

endmodule

// File: rtl/scan_ir_ctrl.sv
`timescale 1ns/1ps
module scan_ir_ctrl
    import scan_ir_pkg::*;
#(
    parameter int              IR_W        = 8,
    parameter logic [IR_W-1:0] CAPTURE_VAL = 8'b0011_1101,
    parameter logic [IR_W-1:0] OP_EXTEST   = 8'b0000_0000,
    parameter logic [IR_W-1:0] OP_SAMPLE   = 8'b1000_0001,
    parameter logic [IR_W-1:0] OP_CLAMP    = 8'b1000_0010,
    parameter logic [IR_W-1:0] OP_HIGHZ    = 8'b0000_0011
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tdi,
    input  logic       tap_reset,
    input  logic       ir_capture,
    input  logic       ir_shift,
    input  logic       ir_update,
    input  logic       dr_capture,
    input  logic       dr_shift,
    input  logic       bsr_tdo,
    output logic [2:0] instr_code,
    output logic       bsr_select,
    output logic       bsr_drive,
    output logic       out_hiz,
    output logic       tdo,
    output logic       tdo_en
);

    localparam logic [IR_W-1:0] RESET_OP = '1;

    logic [IR_W-1:0] ir_shreg;
    logic [IR_W-1:0] ir_hold;
    logic            byp_bit;
    instr_e          instr;

    scan_ir_chain #(
        .IR_W        (IR_W),
        .CAPTURE_VAL (CAPTURE_VAL),
        .RESET_OP    (RESET_OP)
    ) i_chain (
        .tck        (tck),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .tap_reset  (tap_reset),
        .ir_capture (ir_capture),
        .ir_shift   (ir_shift),
        .ir_update  (ir_update),
        .shreg      (ir_shreg),
        .hold       (ir_hold)
    );

    scan_ir_decode #(
        .IR_W      (IR_W),
        .OP_EXTEST (OP_EXTEST),
        .OP_SAMPLE (OP_SAMPLE),
        .OP_CLAMP  (OP_CLAMP),
        .OP_HIGHZ  (OP_HIGHZ)
    ) i_decode (
        .hold       (ir_hold),
        .instr      (instr),
        .bsr_select (bsr_select),
        .bsr_drive  (bsr_drive),
        .out_hiz    (out_hiz)
    );

    scan_bypass_cell i_bypass (
        .tck        (tck),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .bit_q      (byp_bit)
    );

    scan_tdo_stage i_tdo (
        .tck        (tck),
        .rst_n      (rst_n),
        .ir_shift   (ir_shift),
        .dr_shift   (dr_shift),
        .ir_lsb     (ir_shreg[0]),
        .bsr_select (bsr_select),
        .bsr_tdo    (bsr_tdo),
        .byp_bit    (byp_bit),
        .tdo        (tdo),
        .tdo_en     (tdo_en)
    );

    assign instr_code = instr;

endmodule

// File: rtl/scan_ir_ctrl_chk.sv
`timescale 1ns/1ps
module scan_ir_ctrl_chk #(
    parameter int              IR_W        = 8,
    parameter logic [IR_W-1:0] CAPTURE_VAL = 8'b0011_1101
) (
    input logic            tck,
    input logic            rst_n,
    input logic            tdi,
    input logic            tap_reset,
    input logic            ir_capture,
    input logic            ir_update,
    input logic            ir_shift,
    input logic            dr_capture,
    input logic            dr_shift,
    input logic [2:0]      instr_code,
    input logic            bsr_drive,
    input logic            out_hiz,
    input logic            tdo_en,
    input logic [IR_W-1:0] shreg,
    input logic            byp
);

    p_tlr_bypass_r1: assert property (@(posedge tck) disable iff (!rst_n)
        tap_reset |=> (instr_code == 3'd4));

    p_tlr_over_update_r11: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_reset && ir_update) |=> (instr_code == 3'd4 && !bsr_drive && !out_hiz));

    p_capture_value_r2: assert property (@(posedge tck) disable iff (!rst_n)
        ir_capture |=> (shreg == CAPTURE_VAL));

    p_shift_in_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_shift && !ir_capture) |=> (shreg[IR_W-1] == $past(tdi)));

    p_latch_stable_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (!ir_update && !tap_reset) |=> $stable(instr_code));

    p_drive_hiz_excl_r8: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({bsr_drive, out_hiz}));

    p_byp_capture_r9: assert property (@(posedge tck) disable iff (!rst_n)
        dr_capture |=> (byp == 1'b0));

    p_byp_shift_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (dr_shift && !dr_capture) |=> (byp == $past(tdi)));

    p_tdo_on_r10: assert property (@(negedge tck) disable iff (!rst_n)
        (ir_shift || dr_shift) |=> tdo_en);

    p_tdo_off_r10: assert property (@(negedge tck) disable iff (!rst_n)
        (!ir_shift && !dr_shift) |=> !tdo_en);

endmodule

bind scan_ir_ctrl scan_ir_ctrl_chk #(
    .IR_W        (IR_W),
    .CAPTURE_VAL (CAPTURE_VAL)
) i_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .tdi        (tdi),
    .tap_reset  (tap_reset),
    .ir_capture (ir_capture),
    .ir_update  (ir_update),
    .ir_shift   (ir_shift),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .instr_code (instr_code),
    .bsr_drive  (bsr_drive),
    .out_hiz    (out_hiz),
    .tdo_en     (tdo_en),
    .shreg      (ir_shreg),
    .byp        (byp_bit)
);

// File: tb/test_scan_ir_ctrl.sv
`timescale 1ns/1ps
module test_scan_ir_ctrl;

    localparam logic [7:0] CAP = 8'b0011_1101;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tdi = 1'b0;
    logic       tap_reset = 1'b0;
    logic       ir_capture = 1'b0;
    logic       ir_shift = 1'b0;
    logic       ir_update = 1'b0;
    logic       dr_capture = 1'b0;
    logic       dr_shift = 1'b0;
    logic       bsr_tdo = 1'b0;
    logic [2:0] instr_code;
    logic       bsr_select;
    logic       bsr_drive;
    logic       out_hiz;
    logic       tdo;
    logic       tdo_en;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 tck = ~tck;

    scan_ir_ctrl i_scan_ir_ctrl (
        .tck        (tck),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .tap_reset  (tap_reset),
        .ir_capture (ir_capture),
        .ir_shift   (ir_shift),
        .ir_update  (ir_update),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .bsr_tdo    (bsr_tdo),
        .instr_code (instr_code),
        .bsr_select (bsr_select),
        .bsr_drive  (bsr_drive),
        .out_hiz    (out_hiz),
        .tdo        (tdo),
        .tdo_en     (tdo_en)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    function automatic logic [2:0] exp_code(input logic [7:0] v);
        case (v)
            8'h00:   return 3'd0;
            8'h81:   return 3'd1;
            8'h82:   return 3'd2;
            8'h03:   return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic check_decode(input logic [2:0] c, input string req);
        check(instr_code == c, req, instr_code, c);
        check(bsr_select == (c == 3'd0 || c == 3'd1), "R7 select", bsr_select, (c == 3'd0 || c == 3'd1));
        check(bsr_drive == (c == 3'd0 || c == 3'd2), "R8 drive", bsr_drive, (c == 3'd0 || c == 3'd2));
        check(out_hiz == (c == 3'd3), "R8 hiz", out_hiz, (c == 3'd3));
    endtask

    // full instruction scan: checks R2 capture, R3 shift, R4 stability, R10 enable
    task automatic scan_ir(input logic [7:0] v);
        logic [2:0] prev;
        prev = instr_code;
        ir_capture = 1'b1;
        step();
        ir_capture = 1'b0;
        ir_shift = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tdi = v[i];
            @(negedge tck);
            #1;
            check(tdo == CAP[i], "R2 capture bit", tdo, CAP[i]);
            check(tdo_en == 1'b1, "R10 enable on", tdo_en, 1);
            check(instr_code == prev, "R4 stable while shifting", instr_code, prev);
            step();
        end
        ir_shift = 1'b0;
        ir_update = 1'b1;
        @(negedge tck);
        #1;
        check(tdo_en == 1'b0, "R10 enable off", tdo_en, 0);
        step();
        ir_update = 1'b0;
    endtask

    // data scan of n bits; checks R9 (bypass) or R10 (bsr path)
    task automatic scan_dr(input logic [15:0] pat, input logic [15:0] bpat, input logic via_bsr);
        dr_capture = 1'b1;
        step();
        dr_capture = 1'b0;
        dr_shift = 1'b1;
        for (int i = 0; i < 16; i++) begin
            logic e;
            tdi = pat[i];
            bsr_tdo = bpat[i];
            e = via_bsr ? bpat[i] : ((i == 0) ? 1'b0 : pat[i-1]);
            @(negedge tck);
            #1;
            check(tdo == e, via_bsr ? "R10 bsr to tdo" : "R9 bypass path", tdo, e);
            step();
        end
        dr_shift = 1'b0;
        @(negedge tck);
        #1;
        check(tdo_en == 1'b0, "R10 enable off after data", tdo_en, 0);
        step();
    endtask

    initial begin
        #20;
        check(instr_code == 3'd4, "R1 reset code", instr_code, 4);
        check(tdo_en == 1'b0, "R1 reset tdo_en", tdo_en, 0);
        check(bsr_drive == 1'b0 && out_hiz == 1'b0 && bsr_select == 1'b0, "R1 reset controls",
              {bsr_select, bsr_drive, out_hiz}, 0);
        @(negedge tck);
        rst_n = 1'b1;
        step();

        // R5 R6 exhaustive opcode sweep
        for (int v = 0; v < 256; v++) begin
            scan_ir(v[7:0]);
            check_decode(exp_code(v[7:0]), (exp_code(v[7:0]) == 3'd4) ? "R6 fallback" : "R5 decode");
        end

        // R9 bypass data path under several patterns and bypassing instructions
        scan_ir(8'hFF);
        scan_dr(16'hA5C3, 16'h0000, 1'b0);
        scan_ir(8'h82);
        check_decode(3'd2, "R5 clamp");
        scan_dr(16'h0FF1, 16'hFFFF, 1'b0);
        scan_ir(8'h03);
        scan_dr(16'h8001, 16'h5555, 1'b0);

        // R10 boundary register path
        scan_ir(8'h00);
        scan_dr(16'h1234, 16'hC3A5, 1'b1);
        scan_ir(8'h81);
        scan_dr(16'hFFFF, 16'h6E19, 1'b1);

        // R11 tap_reset wins over update; R1 tlr returns to bypass
        scan_ir(8'h00);
        ir_capture = 1'b1;
        step();
        ir_capture = 1'b0;
        ir_shift = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tdi = 1'b0;
            step();
        end
        ir_shift = 1'b0;
        ir_update = 1'b1;
        tap_reset = 1'b1;
        step();
        ir_update = 1'b0;
        tap_reset = 1'b0;
        check_decode(3'd4, "R11 reset beats update");

        scan_ir(8'h82);
        tap_reset = 1'b1;
        step();
        tap_reset = 1'b0;
        check_decode(3'd4, "R1 tlr to bypass");

        // R3 shifted bits are taken as a whole: 0x81 after full scan
        scan_ir(8'h81);
        check_decode(3'd1, "R3 shifted opcode");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule